// File: doc/BRIEF.md
# Shared-Source Stochastic Multiplier

The block multiplies two 8-bit unsigned operands in the stochastic domain. Each operand X is read as the unipolar probability X/256. It becomes a serial bit-stream through a comparator against a pseudo-random value. The two streams are combined with an AND gate, and the ones in the product stream are counted back into a binary result. Both comparators draw on a single maximal-length LFSR. The second comparator sees that sequence through a short chain of D flip-flops. It therefore compares against an older random value than the first one does, so the two streams are not correlated even though they share one source.

A run starts with a single-cycle `start_i` pulse. That pulse captures both operands and the stream length, and reseeds the random source. The product bit is valid for exactly `len_i` cycles, once the delay chain has filled. After the last valid bit, `done_o` pulses for one cycle. `ones_o` then holds the number of ones seen in the product stream until the next run begins.

Top module: `sc_mult_shared_src`

## Requirements
- R1: After reset, `prod_o`, `prod_vld_o`, `done_o` and `ones_o` are all 0, and they stay 0 until a run is started.
- R2: The random source is an 8-bit register. It is loaded with 8'h01 on every accepted start. On each running cycle it shifts toward the MSB, and the XOR of bits 7, 5, 4 and 3 enters bit 0 (polynomial x^8+x^6+x^5+x^4+1). The register is never zero, and it repeats with period 255.
- R3: With R_k the random value k running cycles after the start (R_0 = 8'h01), the first stream bit in cycle k is 1 exactly when R_k < A, where A is the captured first operand.
- R4: An operand of 0 yields an all-zero stream. An operand of 255 yields a 1 in every cycle except the cycle in which its random value is 255.
- R5: The second stream bit in cycle k is 1 exactly when R_(k-D) < B, where B is the captured second operand and D = 2 by default. `prod_vld_o` is high in cycles D through D+len-1, counted from the start edge, and is low otherwise. `prod_o` is 0 whenever `prod_vld_o` is low.
- R6: While it is valid, `prod_o` is the AND of the two stream bits: (R_k < A) & (R_(k-D) < B).
- R7: `done_o` is high for exactly one cycle, D+len cycles after the start edge. At that point `ones_o` equals the number of valid cycles in which `prod_o` was 1, and it holds that value until the next accepted start.
- R8: A start pulse with `len_i` = 0 is ignored. No run begins, `prod_vld_o` and `done_o` stay low, and `ones_o` keeps its previous value.
- R9: A start pulse accepted during a run abandons that run. The new run's timing and count are those of a run started from idle.
- R10: Operands and length are captured on the start cycle. Changing `op_a_i`, `op_b_i` or `len_i` during a run has no effect on the stream or the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | One-cycle pulse that begins a run |
| op_a_i | input | 8 | First operand, probability op_a_i/256 |
| op_b_i | input | 8 | Second operand, probability op_b_i/256 |
| len_i | input | 8 | Number of product bits to accumulate (0 ignores the start) |
| prod_o | output | 1 | Product stream bit of the current cycle |
| prod_vld_o | output | 1 | High while prod_o is part of the counted stream |
| ones_o | output | 8 | Count of ones in the product stream |
| done_o | output | 1 | One-cycle pulse after the last counted bit |

## Verification
The assertions assume that `rst_n` is released synchronously. They also assume that `start_i` only acts as a clean pulse sampled at a clock edge. A start with length zero is assumed not to disturb an idle block. The delay-chain stage checks assume each stage moves only on running cycles that are not also restarts. The stimulus changes every input on falling edges and drives `start_i` high for one cycle at a time. Operand changes during a run and restarts in the middle of a run are the only deliberate departures from a quiet interface, and they exercise the capture and restart behaviour directly.

// File: rtl/sc_mult_pkg.sv
package sc_mult_pkg;
  // width of the random source and of each operand
  localparam int unsigned RNG_W = 8;
  // feedback taps for x^8+x^6+x^5+x^4+1, shift toward the MSB
  localparam logic [RNG_W-1:0] RNG_TAPS = 8'hB8;
  // nonzero value loaded at every accepted start
  localparam logic [RNG_W-1:0] RNG_SEED = 8'h01;

  typedef enum logic {
    RUN_IDLE = 1'b0,
    RUN_BUSY = 1'b1
  } run_state_e;
endpackage

// File: rtl/sc_lfsr.sv
module sc_lfsr #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] SEED = 8'h01
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  output logic [W-1:0] r_o
);
  logic [W-1:0] r_q;
  logic [W-1:0] r_d;
  logic         fb;

  always_comb begin
    fb  = ^(r_q & TAPS);
    r_d = r_q;
    if (load_i)      r_d = SEED;
    else if (step_i) r_d = {r_q[W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) r_q <= SEED;
    else        r_q <= r_d;
  end

  assign r_o = r_q;

  assert_lfsr_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    r_q != '0);
  assert_lfsr_seeded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (r_q == SEED));
endmodule

// File: rtl/sc_delay_line.sv
module sc_delay_line #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (DEPTH == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [W-1:0] stage_q [DEPTH];
      logic [W-1:0] stage_d [DEPTH];

      for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        always_comb begin
          stage_d[i] = stage_q[i];
          if (clr_i)        stage_d[i] = '0;
          else if (shift_i) stage_d[i] = (i == 0) ? d_i : stage_q[(i == 0) ? 0 : i-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= '0;
          else        stage_q[i] <= stage_d[i];
        end

        if (i > 0) begin : g_chk
          assert_stage_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (shift_i && !clr_i) |=> (stage_q[i] == $past(stage_q[i-1])));
        end
      end

      assign q_o = stage_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/sc_sng.sv
module sc_sng #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] r_i,
  input  logic [W-1:0] x_i,
  output logic         bit_o
);
  // unipolar encoding: one when the random value lies below the operand
  assign bit_o = (r_i < x_i);
endmodule

// File: rtl/sc_ones_counter.sv
module sc_ones_counter #(
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             bit_vld_i,
  input  logic             bit_i,
  output logic             last_o,
  output logic [LEN_W-1:0] ones_o,
  output logic             done_o
);
  logic [LEN_W-1:0] rem_q, rem_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;

  assign last_o = bit_vld_i && (rem_q == LEN_W'(1));

  always_comb begin
    rem_d  = rem_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (clr_i) begin
      rem_d = len_i;
      cnt_d = '0;
    end else if (bit_vld_i) begin
      rem_d  = rem_q - LEN_W'(1);
      cnt_d  = cnt_q + LEN_W'(bit_i);
      done_d = last_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign ones_o = cnt_q;
  assign done_o = done_q;

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld_i |-> (rem_q != '0));
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_count_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !bit_vld_i) |=> $stable(cnt_q));
endmodule

// File: rtl/sc_mult_shared_src.sv
module sc_mult_shared_src #(
  parameter int unsigned DLY   = 2,
  parameter int unsigned LEN_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic [sc_mult_pkg::RNG_W-1:0] op_a_i,
  input  logic [sc_mult_pkg::RNG_W-1:0] op_b_i,
  input  logic [LEN_W-1:0]              len_i,
  output logic                          prod_o,
  output logic                          prod_vld_o,
  output logic [LEN_W-1:0]              ones_o,
  output logic                          done_o
);
  import sc_mult_pkg::*;

  localparam int unsigned FILL_W = $clog2(DLY + 2);

  run_state_e       run_q, run_d;
  logic [FILL_W-1:0] fill_q, fill_d;
  logic [RNG_W-1:0] opa_q, opa_d, opb_q, opb_d;
  logic [RNG_W-1:0] r_now, r_old;
  logic             go, running, filled, step;
  logic             bit_a, bit_b, last;

  assign go      = start_i && (len_i != '0);
  assign running = (run_q == RUN_BUSY);
  assign filled  = (fill_q == FILL_W'(DLY));
  assign step    = running && !go;

  always_comb begin
    run_d  = run_q;
    fill_d = fill_q;
    opa_d  = opa_q;
    opb_d  = opb_q;
    if (go) begin
      run_d  = RUN_BUSY;
      fill_d = '0;
      opa_d  = op_a_i;
      opb_d  = op_b_i;
    end else begin
      if (last)                 run_d  = RUN_IDLE;
      if (running && !filled)   fill_d = fill_q + FILL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= RUN_IDLE;
      fill_q <= '0;
      opa_q  <= '0;
      opb_q  <= '0;
    end else begin
      run_q  <= run_d;
      fill_q <= fill_d;
      opa_q  <= opa_d;
      opb_q  <= opb_d;
    end
  end

  sc_lfsr #(.W(RNG_W), .TAPS(RNG_TAPS), .SEED(RNG_SEED)) rng_i (
    .clk(clk), .rst_n(rst_n), .load_i(go), .step_i(step), .r_o(r_now)
  );

  sc_delay_line #(.W(RNG_W), .DEPTH(DLY)) tap_i (
    .clk(clk), .rst_n(rst_n), .clr_i(go), .shift_i(step), .d_i(r_now), .q_o(r_old)
  );

  sc_sng #(.W(RNG_W)) sng_a_i (.r_i(r_now), .x_i(opa_q), .bit_o(bit_a));
  sc_sng #(.W(RNG_W)) sng_b_i (.r_i(r_old), .x_i(opb_q), .bit_o(bit_b));

  assign prod_vld_o = running && filled;
  assign prod_o     = prod_vld_o && bit_a && bit_b;

  sc_ones_counter #(.LEN_W(LEN_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .clr_i(go), .len_i(len_i),
    .bit_vld_i(prod_vld_o), .bit_i(prod_o), .last_o(last),
    .ones_o(ones_o), .done_o(done_o)
  );

  assert_quiet_invalid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !prod_vld_o |-> !prod_o);
  assert_full_scale_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (opa_q == '1 && r_now != '1) |-> bit_a);
  assert_empty_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && len_i == '0 && !running) |=> !running);
  assert_done_ends_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !prod_vld_o);
endmodule

// File: tb/sc_mult_shared_src_tb_top.sv
module sc_mult_shared_src_tb_top;
  localparam int D = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [7:0] op_a_i, op_b_i, len_i;
  logic       prod_o, prod_vld_o, done_o;
  logic [7:0] ones_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] seq [0:511];

  always #10 clk = ~clk;

  sc_mult_shared_src dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_a_i(op_a_i), .op_b_i(op_b_i),
    .len_i(len_i), .prod_o(prod_o), .prod_vld_o(prod_vld_o), .ones_o(ones_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one run: start, watch every cycle against the model, check count and done timing
  task automatic run_case(input int a, input int b, input int len, input bit scramble);
    int vld_bad = 0, bit_bad = 0, done_bad = 0, exp_cnt = 0, got_cnt = -1;
    @(negedge clk);
    op_a_i = 8'(a); op_b_i = 8'(b); len_i = 8'(len); start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    if (scramble) begin op_a_i = ~8'(a); op_b_i = ~8'(b); len_i = 8'd3; end
    for (int j = 0; j <= D + len + 2; j++) begin
      bit ev, ed, eb;
      ev = (j >= D) && (j < D + len);
      ed = (j == D + len);
      eb = ev && (seq[j] < 8'(a)) && (seq[(j >= D) ? j - D : 0] < 8'(b));
      if (prod_vld_o !== ev) vld_bad++;
      if (prod_o !== eb) bit_bad++;
      if (done_o !== ed) done_bad++;
      if (eb) exp_cnt++;
      if (ed) got_cnt = int'(ones_o);
      @(negedge clk);
    end
    chk(vld_bad == 0, "R5", $sformatf("valid window a=%0d b=%0d len=%0d", a, b, len), vld_bad, 0);
    chk(bit_bad == 0, "R6", $sformatf("product bits a=%0d b=%0d", a, b), bit_bad, 0);
    chk(done_bad == 0, "R7", "done pulse timing", done_bad, 0);
    chk(got_cnt == exp_cnt, scramble ? "R10" : "R7", "ones count", got_cnt, exp_cnt);
    chk(int'(ones_o) == exp_cnt, "R7", "ones held after done", int'(ones_o), exp_cnt);
  endtask

  task automatic test_reset();
    chk(prod_o == 0 && prod_vld_o == 0 && done_o == 0, "R1", "outputs idle after reset",
        int'({prod_o, prod_vld_o, done_o}), 0);
    chk(ones_o == 0, "R1", "count zero after reset", int'(ones_o), 0);
  endtask

  task automatic test_operands();
    run_case(0, 200, 255, 0);    // R4 zero operand on first input
    run_case(200, 0, 255, 0);    // R4 zero operand on second input
    run_case(1, 255, 255, 0);    // R2 source never zero, so A=1 gives nothing
    run_case(255, 255, 255, 0);  // R4 full scale on both inputs
    run_case(128, 128, 255, 0);  // R3 mid scale
    run_case(64, 192, 255, 0);
    run_case(37, 211, 255, 0);
    run_case(250, 90, 100, 0);
    run_case(255, 255, 1, 0);    // shortest run
    run_case(170, 85, 10, 0);
  endtask

  task automatic test_full_scale_count();
    // R4: both 255 over a full period: ones except the two cycles where a random value is 255
    run_case(255, 255, 255, 0);
    chk(ones_o == 8'd253, "R4", "full scale count", int'(ones_o), 253);
  endtask

  task automatic test_capture();
    run_case(99, 180, 200, 1);   // R10 inputs scrambled after the start
  endtask

  task automatic test_restart();
    @(negedge clk);
    op_a_i = 8'd10; op_b_i = 8'd20; len_i = 8'd255; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (20) @(negedge clk);
    run_case(140, 230, 150, 0);  // R9 restart mid-run behaves like a fresh run
  endtask

  task automatic test_empty_start();
    logic [7:0] held;
    int bad = 0;
    held = ones_o;
    @(negedge clk);
    op_a_i = 8'd255; op_b_i = 8'd255; len_i = 8'd0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; len_i = 8'd255;
    for (int j = 0; j < 300; j++) begin
      if (prod_vld_o || done_o || prod_o || ones_o != held) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R8", "zero-length start ignored", bad, 0);
    chk(ones_o == held, "R8", "count unchanged", int'(ones_o), int'(held));
  endtask

  initial begin
    seq[0] = 8'h01;
    for (int i = 0; i < 511; i++)
      seq[i+1] = {seq[i][6:0], seq[i][7] ^ seq[i][5] ^ seq[i][4] ^ seq[i][3]};
    begin
      int per = 0;
      for (int i = 1; i < 300; i++) if (per == 0 && seq[i] == 8'h01) per = i;
      chk(per == 255, "R2", "model period", per, 255);
    end
    rst_n = 1'b0; start_i = 1'b0; op_a_i = '0; op_b_i = '0; len_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_reset();
    test_operands();
    test_full_scale_count();
    test_capture();
    test_restart();
    test_empty_start();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule